// File: doc/BRIEF.md
# Replicated-Register Steering Target Calculator

Some registers in a graphics engine exist as one copy per hardware unit behind a single address. A unicast read must be steered to a copy whose unit is present, because a read aimed at a fused-off or power-gated unit returns zero. This block takes fuse masks and engine-presence bits and works out a (group, instance) steering target for each family of replicated registers. It holds the results in registers for the access sequencer that programs the steering selector.

After reset the block walks through the register families one per clock. It stores each family's target and raises that family's initialized flag. When the walk is finished it raises `done`, and from then on all outputs stay frozen until the next reset. A 2-bit layout select chooses which rules apply. The family that always steers to instance 0 needs no computation, so its flag is already set while reset is held. Inputs must be stable from reset release until `done` rises. All pins are plain control and status levels, so there is no handshake and no back-pressure.

Top module: `steer_target_calc`

## Requirements
- R1: While `rst_n` is low, every target output and `ss_per_grp` is 0 and `done` is 0. In `init_flags`, bit 6 (fixed instance-0 family) is 1 and bits 0..5 are 0.
- R2: One family is computed per clock after reset release, in this order: cache bank (flag bit 0) on the 1st rising edge; memory slice and line-fill (bits 1 and 2) on the 2nd; group size on the 3rd; subslice (bit 3) on the 4th; media output unit (bit 4) on the 5th; node (bit 5) on the 6th, which also sets `done`.
- R3: With `layout_sel` 0 or 3, the cache-bank group is the lowest set index of `msl_en`. The instance is 0 when `bank0_on` is 1 and 2 when it is 0.
- R4: With `layout_sel` 1, a bank number equal to (lowest set index of `msl_en`) × 8 is formed. The cache-bank group is bank[4:2] and the instance is bank[1:0].
- R5: With `layout_sel` 2, the cache-bank group is 0 and the instance is the lowest set index of the bitwise inverse of `l3_dis_fuse`.
- R6: The memory-slice group is the lowest set index of `msl_en`, and the line-fill group is that index shifted left by one. Both instances are 0 and are not output.
- R7: `ss_per_grp` is ceil(`max_subslices` / `max_slices`) when both are nonzero. Otherwise it falls back to 8 for layout 3, 6 for layout 2, and 4 for layouts 0 and 1.
- R8: The subslice index is the lower of the lowest set indices of `ss_geo_mask` and `ss_cmp_mask`, and an empty mask does not take part. `ss_grp` is that index divided by `ss_per_grp` and `ss_inst` is the remainder.
- R9: `media_grp` is 0 when `vid0_on` or `venh0_on` is 1, and 1 when both are 0.
- R10: With n the lowest set index of `node_en`, `node_grp` is n >> 1 and `node_inst` is n & 1.
- R11: Any lowest-set-index lookup on an all-zero mask yields 0. When both subslice masks are empty, the subslice index is 0.
- R12: Once `done` is 1, changes on any input have no effect on the outputs until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it starts the walk |
| layout_sel | input | 2 | Rule set: 0 newer, 1 bank-packing, 2 oldest, 3 wide-group |
| msl_en | input | MSL_W | Memory-slice enable mask |
| bank0_on | input | 1 | Bit 0 of the cache-bank mask |
| l3_dis_fuse | input | L3D_W | Cache-bank disable fuse field (oldest layout) |
| ss_geo_mask | input | SS_W | Geometry subslice presence mask |
| ss_cmp_mask | input | SS_W | Compute subslice presence mask |
| max_slices | input | CNT_W | Maximum slice count, 0 if unknown |
| max_subslices | input | CNT_W | Maximum subslice count, 0 if unknown |
| vid0_on | input | 1 | First video engine present |
| venh0_on | input | 1 | First video-enhancement engine present |
| node_en | input | NODE_W | Node enable mask |
| l3_grp | output | GRP_W | Cache-bank group target |
| l3_inst | output | INST_W | Cache-bank instance target |
| msl_grp | output | GRP_W | Memory-slice group target |
| lncf_grp | output | GRP_W | Line-fill group target |
| ss_per_grp | output | CNT_W | Subslices per group |
| ss_grp | output | GRP_W | Subslice group target |
| ss_inst | output | INST_W | Subslice instance target |
| media_grp | output | GRP_W | Media output-unit group target |
| node_grp | output | GRP_W | Node group target |
| node_inst | output | INST_W | Node instance target |
| init_flags | output | 7 | Per-family initialized flags |
| done | output | 1 | All families computed |

## Verification
The bench goes after the following corner cases:
- `bank0_on` low in the newer layout. A design that mishandled it would leave the instance at 0, which is a terminated bank.
- The bank-packing split. A wrong slice of the bank number would put a nonzero instance or a wrong group on the outputs.
- Subslice masks where the compute mask holds the lower index, where one mask is empty, and where both are empty. A design that always used one mask, or treated an empty mask as index 0 in the comparison, would pick the wrong unit.
- Both the ceiling division and each fallback count. A floor division or a missing fallback would change `ss_grp` and `ss_inst`.
- Inputs changed after `done`. A design that kept computing would let its outputs drift after completion.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    LAY_NEW  = 2'd0,
    LAY_PACK = 2'd1,
    LAY_OLD  = 2'd2,
    LAY_WIDE = 2'd3
  } layout_e;

  typedef enum logic [2:0] {
    ST_L3    = 3'd0,
    ST_MSL   = 3'd1,
    ST_CNT   = 3'd2,
    ST_SS    = 3'd3,
    ST_MEDIA = 3'd4,
    ST_NODE  = 3'd5,
    ST_IDLE  = 3'd6
  } step_e;

  localparam int NUM_TYPES = 7;
  localparam int F_L3    = 0;
  localparam int F_MSL   = 1;
  localparam int F_LNCF  = 2;
  localparam int F_SS    = 3;
  localparam int F_MEDIA = 4;
  localparam int F_NODE  = 5;
  localparam int F_FIXED = 6;
endpackage

// File: rtl/steer_first_set.sv
module steer_first_set #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/steer_l3_rule.sv
module steer_l3_rule
  import steer_pkg::*;
#(
  parameter int MSL_W  = 4,
  parameter int L3D_W  = 8,
  parameter int GRP_W  = 8,
  parameter int INST_W = 8,
  localparam int MSL_IW = (MSL_W > 1) ? $clog2(MSL_W) : 1,
  localparam int L3D_IW = (L3D_W > 1) ? $clog2(L3D_W) : 1
) (
  input  layout_e             layout,
  input  logic [MSL_IW-1:0]   msl_idx,
  input  logic                bank0_on,
  input  logic [L3D_W-1:0]    l3_dis_fuse,
  output logic [GRP_W-1:0]    grp,
  output logic [INST_W-1:0]   inst
);
  logic [L3D_IW-1:0] free_idx;
  logic [4:0]        bank_num;

  steer_first_set #(.W(L3D_W)) u_free (.mask(~l3_dis_fuse), .idx(free_idx));

  assign bank_num = 5'(msl_idx) << 3;

  always_comb begin
    unique case (layout)
      LAY_PACK: begin
        grp  = GRP_W'(bank_num[4:2]);
        inst = INST_W'(bank_num[1:0]);
      end
      LAY_OLD: begin
        grp  = '0;
        inst = INST_W'(free_idx);
      end
      default: begin
        grp  = GRP_W'(msl_idx);
        inst = bank0_on ? '0 : INST_W'(2);
      end
    endcase
  end
endmodule

// File: rtl/steer_ss_split.sv
module steer_ss_split #(
  parameter int SS_W   = 32,
  parameter int CNT_W  = 8,
  parameter int GRP_W  = 8,
  parameter int INST_W = 8,
  localparam int SS_IW = (SS_W > 1) ? $clog2(SS_W) : 1
) (
  input  logic [SS_W-1:0]   geo_mask,
  input  logic [SS_W-1:0]   cmp_mask,
  input  logic [CNT_W-1:0]  per_grp,
  output logic [GRP_W-1:0]  grp,
  output logic [INST_W-1:0] inst
);
  logic [SS_IW-1:0] geo_idx, cmp_idx, pick;
  logic             geo_any, cmp_any;
  logic [CNT_W-1:0] idx_ext, divisor;

  steer_first_set #(.W(SS_W)) u_geo (.mask(geo_mask), .idx(geo_idx));
  steer_first_set #(.W(SS_W)) u_cmp (.mask(cmp_mask), .idx(cmp_idx));

  assign geo_any = |geo_mask;
  assign cmp_any = |cmp_mask;

  always_comb begin
    if (geo_any && (!cmp_any || geo_idx <= cmp_idx)) pick = geo_idx;
    else if (cmp_any)                                 pick = cmp_idx;
    else                                              pick = '0;
    idx_ext = CNT_W'(pick);
    divisor = (per_grp == '0) ? CNT_W'(1) : per_grp;
    grp     = GRP_W'(idx_ext / divisor);
    inst    = INST_W'(idx_ext % divisor);
  end
endmodule

// File: rtl/steer_target_calc.sv
module steer_target_calc
  import steer_pkg::*;
#(
  parameter int MSL_W  = 4,
  parameter int L3D_W  = 8,
  parameter int SS_W   = 32,
  parameter int NODE_W = 8,
  parameter int CNT_W  = 8,
  parameter int GRP_W  = 8,
  parameter int INST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         layout_sel,
  input  logic [MSL_W-1:0]   msl_en,
  input  logic               bank0_on,
  input  logic [L3D_W-1:0]   l3_dis_fuse,
  input  logic [SS_W-1:0]    ss_geo_mask,
  input  logic [SS_W-1:0]    ss_cmp_mask,
  input  logic [CNT_W-1:0]   max_slices,
  input  logic [CNT_W-1:0]   max_subslices,
  input  logic               vid0_on,
  input  logic               venh0_on,
  input  logic [NODE_W-1:0]  node_en,
  output logic [GRP_W-1:0]   l3_grp,
  output logic [INST_W-1:0]  l3_inst,
  output logic [GRP_W-1:0]   msl_grp,
  output logic [GRP_W-1:0]   lncf_grp,
  output logic [CNT_W-1:0]   ss_per_grp,
  output logic [GRP_W-1:0]   ss_grp,
  output logic [INST_W-1:0]  ss_inst,
  output logic [GRP_W-1:0]   media_grp,
  output logic [GRP_W-1:0]   node_grp,
  output logic [INST_W-1:0]  node_inst,
  output logic [NUM_TYPES-1:0] init_flags,
  output logic               done
);
  localparam int MSL_IW  = (MSL_W > 1) ? $clog2(MSL_W) : 1;
  localparam int NODE_IW = (NODE_W > 1) ? $clog2(NODE_W) : 1;
  localparam logic [NUM_TYPES-1:0] FLAGS_RST = NUM_TYPES'(1) << F_FIXED;

  layout_e              layout;
  step_e                step;
  logic [MSL_IW-1:0]    msl_idx;
  logic [NODE_IW-1:0]   node_idx;
  logic [GRP_W-1:0]     l3_grp_c, ss_grp_c;
  logic [INST_W-1:0]    l3_inst_c, ss_inst_c;
  logic [CNT_W-1:0]     grp_cnt_c;
  logic [CNT_W:0]       ceil_num;

  assign layout = layout_e'(layout_sel);

  steer_first_set #(.W(MSL_W))  u_msl  (.mask(msl_en),  .idx(msl_idx));
  steer_first_set #(.W(NODE_W)) u_node (.mask(node_en), .idx(node_idx));

  steer_l3_rule #(
    .MSL_W(MSL_W), .L3D_W(L3D_W), .GRP_W(GRP_W), .INST_W(INST_W)
  ) u_l3 (
    .layout(layout), .msl_idx(msl_idx), .bank0_on(bank0_on),
    .l3_dis_fuse(l3_dis_fuse), .grp(l3_grp_c), .inst(l3_inst_c)
  );

  steer_ss_split #(
    .SS_W(SS_W), .CNT_W(CNT_W), .GRP_W(GRP_W), .INST_W(INST_W)
  ) u_ss (
    .geo_mask(ss_geo_mask), .cmp_mask(ss_cmp_mask), .per_grp(ss_per_grp),
    .grp(ss_grp_c), .inst(ss_inst_c)
  );

  // subslices per group: ceiling quotient or per-layout fallback
  always_comb begin
    ceil_num = (CNT_W+1)'(max_subslices) + (CNT_W+1)'(max_slices) - (CNT_W+1)'(1);
    if (max_slices != '0 && max_subslices != '0)
      grp_cnt_c = CNT_W'(ceil_num / (CNT_W+1)'(max_slices));
    else if (layout == LAY_WIDE)
      grp_cnt_c = CNT_W'(8);
    else if (layout == LAY_OLD)
      grp_cnt_c = CNT_W'(6);
    else
      grp_cnt_c = CNT_W'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= ST_L3;
      l3_grp     <= '0;
      l3_inst    <= '0;
      msl_grp    <= '0;
      lncf_grp   <= '0;
      ss_per_grp <= '0;
      ss_grp     <= '0;
      ss_inst    <= '0;
      media_grp  <= '0;
      node_grp   <= '0;
      node_inst  <= '0;
      init_flags <= FLAGS_RST;
      done       <= 1'b0;
    end else begin
      unique case (step)
        ST_L3: begin
          l3_grp           <= l3_grp_c;
          l3_inst          <= l3_inst_c;
          init_flags[F_L3] <= 1'b1;
          step             <= ST_MSL;
        end
        ST_MSL: begin
          msl_grp            <= GRP_W'(msl_idx);
          lncf_grp           <= GRP_W'(msl_idx) << 1;
          init_flags[F_MSL]  <= 1'b1;
          init_flags[F_LNCF] <= 1'b1;
          step               <= ST_CNT;
        end
        ST_CNT: begin
          ss_per_grp <= grp_cnt_c;
          step       <= ST_SS;
        end
        ST_SS: begin
          ss_grp           <= ss_grp_c;
          ss_inst          <= ss_inst_c;
          init_flags[F_SS] <= 1'b1;
          step             <= ST_MEDIA;
        end
        ST_MEDIA: begin
          media_grp           <= (vid0_on || venh0_on) ? '0 : GRP_W'(1);
          init_flags[F_MEDIA] <= 1'b1;
          step                <= ST_NODE;
        end
        ST_NODE: begin
          node_grp           <= GRP_W'(node_idx >> 1);
          node_inst          <= INST_W'(node_idx[0]);
          init_flags[F_NODE] <= 1'b1;
          done               <= 1'b1;
          step               <= ST_IDLE;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

  assert_fixed_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_flags[F_FIXED]);
  assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_done_all_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&init_flags));
  assert_flag_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_flags[F_SS] |-> (init_flags[F_L3] && init_flags[F_MSL] && init_flags[F_LNCF]));
  assert_cnt_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_flags[F_SS] |-> (ss_per_grp != '0));
  assert_inst_below_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_flags[F_SS] |-> (32'(ss_inst) < 32'(ss_per_grp)));
  assert_frozen_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(l3_grp) && $stable(l3_inst) && $stable(ss_grp) && $stable(ss_inst)
              && $stable(msl_grp) && $stable(node_grp) && $stable(media_grp)));
endmodule

// File: tb/sim_steer_target_calc.sv
module sim_steer_target_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  layout_sel = '0;
  logic [3:0]  msl_en = '0;
  logic        bank0_on = 1'b0;
  logic [7:0]  l3_dis_fuse = '0;
  logic [31:0] ss_geo_mask = '0, ss_cmp_mask = '0;
  logic [7:0]  max_slices = '0, max_subslices = '0;
  logic        vid0_on = 1'b0, venh0_on = 1'b0;
  logic [7:0]  node_en = '0;
  logic [7:0]  l3_grp, l3_inst, msl_grp, lncf_grp, ss_per_grp, ss_grp, ss_inst;
  logic [7:0]  media_grp, node_grp, node_inst;
  logic [6:0]  init_flags;
  logic        done;

  int tests = 0, fails = 0;
  int e_l3g, e_l3i, e_msl, e_lncf, e_cnt, e_ssg, e_ssi, e_med, e_ndg, e_ndi, e_flags, e_done;
  string l3tag;

  always #5 clk = ~clk;

  steer_target_calc u0 (.*);

  function automatic int lowest(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int low0(input logic [31:0] m);
    int v = lowest(m);
    return (v < 0) ? 0 : v;   // R11: empty mask gives 0
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v);
    tests++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic compare_all(input string ph);
    chk({ph, " ", l3tag, " l3_grp"}, int'(l3_grp), e_l3g);
    chk({ph, " ", l3tag, " l3_inst"}, int'(l3_inst), e_l3i);
    chk({ph, " R6 msl_grp"}, int'(msl_grp), e_msl);
    chk({ph, " R6 lncf_grp"}, int'(lncf_grp), e_lncf);
    chk({ph, " R7 ss_per_grp"}, int'(ss_per_grp), e_cnt);
    chk({ph, " R8 ss_grp"}, int'(ss_grp), e_ssg);
    chk({ph, " R8 ss_inst"}, int'(ss_inst), e_ssi);
    chk({ph, " R9 media_grp"}, int'(media_grp), e_med);
    chk({ph, " R10 node_grp"}, int'(node_grp), e_ndg);
    chk({ph, " R10 node_inst"}, int'(node_inst), e_ndi);
    chk({ph, " R2 init_flags"}, int'(init_flags), e_flags);
    chk({ph, " R2 done"}, int'(done), e_done);
  endtask

  // behavioural reference: apply edge number k after reset release
  task automatic model_step(input int k);
    int ms, b, gi, ci, ix;
    ms = low0({28'b0, msl_en});
    case (k)
      1: begin
        if (layout_sel == 2'd1) begin
          b = ms * 8; e_l3g = (b >> 2) & 7; e_l3i = b & 3;
        end else if (layout_sel == 2'd2) begin
          e_l3g = 0; e_l3i = low0({24'b0, ~l3_dis_fuse});
        end else begin
          e_l3g = ms; e_l3i = bank0_on ? 0 : 2;
        end
        e_flags = e_flags | 1;
      end
      2: begin e_msl = ms; e_lncf = ms * 2; e_flags = e_flags | 6; end
      3: begin
        if (max_slices != 0 && max_subslices != 0)
          e_cnt = (int'(max_subslices) + int'(max_slices) - 1) / int'(max_slices);
        else e_cnt = (layout_sel == 2'd3) ? 8 : (layout_sel == 2'd2) ? 6 : 4;
      end
      4: begin
        gi = lowest(ss_geo_mask); ci = lowest(ss_cmp_mask);
        if (gi < 0 && ci < 0) ix = 0;
        else if (gi < 0) ix = ci;
        else if (ci < 0) ix = gi;
        else ix = (gi < ci) ? gi : ci;
        e_ssg = ix / e_cnt; e_ssi = ix % e_cnt; e_flags = e_flags | 8;
      end
      5: begin e_med = (vid0_on || venh0_on) ? 0 : 1; e_flags = e_flags | 16; end
      6: begin
        ix = low0({24'b0, node_en});
        e_ndg = ix >> 1; e_ndi = ix & 1; e_flags = e_flags | 32; e_done = 1;
      end
      default: ;
    endcase
  endtask

  task automatic run_case(input logic [1:0] lay, input logic [3:0] msl, input logic b0,
                          input logic [7:0] dis, input logic [31:0] geo, input logic [31:0] cmp,
                          input logic [7:0] msl_cnt, input logic [7:0] msub,
                          input logic v, input logic e, input logic [7:0] nd);
    @(negedge clk);
    rst_n = 1'b0;
    layout_sel = lay; msl_en = msl; bank0_on = b0; l3_dis_fuse = dis;
    ss_geo_mask = geo; ss_cmp_mask = cmp; max_slices = msl_cnt; max_subslices = msub;
    vid0_on = v; venh0_on = e; node_en = nd;
    l3tag = (lay == 2'd1) ? "R4" : (lay == 2'd2) ? "R5" : "R3";
    e_l3g = 0; e_l3i = 0; e_msl = 0; e_lncf = 0; e_cnt = 0; e_ssg = 0; e_ssi = 0;
    e_med = 0; e_ndg = 0; e_ndi = 0; e_flags = 64; e_done = 0;
    @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk);
      model_step(k);
      @(negedge clk);
      compare_all("R2 walk");
    end
    // R12: disturb every input after done; outputs must not move
    layout_sel = ~lay; msl_en = ~msl; bank0_on = ~b0; l3_dis_fuse = ~dis;
    ss_geo_mask = ~geo; ss_cmp_mask = 32'h1; max_slices = 8'd1; max_subslices = 8'd3;
    vid0_on = ~v; venh0_on = ~e; node_en = ~nd;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      compare_all("R12 hold");
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // newer layout, bank0 absent, compute mask wins, exact ceiling
    run_case(2'd0, 4'b0100, 1'b0, 8'h00, 32'h30, 32'h0C, 8'd2, 8'd8, 1'b1, 1'b0, 8'b0000_1100);
    // bank packing, geometry only, rounded-up ceiling, no media engines
    run_case(2'd1, 4'b0110, 1'b1, 8'h00, 32'h1 << 13, 32'h0, 8'd3, 8'd10, 1'b0, 1'b0, 8'h80);
    // oldest layout, inverted fuse, fallback 6
    run_case(2'd2, 4'b0001, 1'b0, 8'h07, 32'h1 << 20, 32'h1 << 17, 8'd0, 8'd12, 1'b0, 1'b1, 8'h02);
    // wide layout, fallback 8, top subslice
    run_case(2'd3, 4'b1000, 1'b1, 8'h00, 32'h0, 32'h8000_0000, 8'd4, 8'd0, 1'b1, 1'b1, 8'h40);
    // R11: every mask empty
    run_case(2'd0, 4'b0000, 1'b1, 8'hFF, 32'h0, 32'h0, 8'd1, 8'd1, 1'b0, 1'b0, 8'h00);
    // packing with highest slice, fallback 4
    run_case(2'd1, 4'b1000, 1'b0, 8'h00, 32'h1 << 9, 32'h1 << 9, 8'd5, 8'd0, 1'b0, 1'b1, 8'h10);
    // oldest layout with all fuses set (empty inverse)
    run_case(2'd2, 4'b0010, 1'b1, 8'hFF, 32'h4, 32'h0, 8'd6, 8'd40, 1'b1, 1'b0, 8'h05);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule